// File: doc/BRIEF.md
# Image Sensor Configuration Sequencer

This block runs the control side of an image sensor that is set up over a three-wire serial link (sensor clock, serial data, load strobe) plus separate reset and start-of-exposure lines. A single request from the system starts a fixed session. The block pulses the sensor reset, then writes the sensor's eight configuration registers in ascending order. After that it issues the start-of-exposure command and keeps clocking the sensor until the sensor reports that image data is ready. The block then raises a one-cycle done pulse and hands the sensor clock over to a separate capture block.

Every register write is an 11-bit frame: a 3-bit register number, then an 8-bit value, with the most significant bit of each field sent first. A rising edge of the load strobe closes the frame. The sensor clock comes from the system clock. Each sensor clock level, and each step of the pin sequence, lasts `HALF_CYC` system cycles. Only one of the control pins moves per step, so the setup and hold order that the sensor expects is kept at any divider value.

The eight register values come from a parameter or from an input array, chosen by `USE_PORT`. The parameter default for registers 0 to 7 is 0x9F, 0x07, 0x08, 0xFF, 0x01, 0x00, 0x01, 0x03. Registers 2 and 3 together form the 16-bit exposure count, high byte first, in steps of 16 microseconds. In the input array, register k sits in bits 8k+7 down to 8k. The array is read live, frame by frame, so it must stay stable while `busy` is high.

Top module: `img_seq_ctrl`

## Requirements
- R1: After reset, and whenever idle, `sns_clk`=0, `sns_rst_n`=1, `sns_load`=0, `sns_start`=0, `busy`=0 and `done`=0; `clk_handoff` is 0 after reset.
- R2: A `start_req` high while idle makes `busy` high at the next clock edge and clears `clk_handoff`; a `start_req` while busy is ignored, so the session keeps exactly one reset pulse and eight frames in order.
- R3: The reset phase lowers `sns_rst_n` while `sns_clk` is low, gives exactly one rising edge of `sns_clk` while `sns_rst_n` is low, and raises `sns_rst_n` again before `sns_clk` falls.
- R4: Eight frames follow, for registers 0 to 7 in ascending order. Each frame has exactly 11 rising `sns_clk` edges while `sns_load` is low. The bits taken on those edges are the 3-bit register number and then the 8-bit value (array bits 8k+7:8k), MSB first.
- R5: `sns_data` never changes while `sns_clk` stays high; it changes only while the clock is low or on the cycle the clock falls.
- R6: `sns_load` rises while `sns_clk` is high after the 11th bit; `sns_clk` then falls, and only then does `sns_load` fall.
- R7: The start command raises `sns_start` while `sns_clk` is low, gives exactly one rising `sns_clk` edge with `sns_start` high, and drops `sns_start` before `sns_clk` falls.
- R8: After the start command, `sns_clk` keeps toggling and `sns_ready` is sampled at the end of each high phase. The number of rising edges after the start command equals the number of the high phase in which `sns_ready` was first seen high.
- R9: When `sns_ready` is seen, `done` is high for exactly one cycle, `busy` drops in that same cycle, `sns_clk` is left low and `clk_handoff` goes high. `clk_handoff` stays high until the next accepted start.
- R10: Every level of `sns_clk` lasts at least `HALF_CYC` system cycles, and at most one of `sns_clk`, `sns_rst_n`, `sns_load` and `sns_start` changes in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to run one session |
| cfg_vals | input | 64 | Register values when `USE_PORT`=1, register k in bits 8k+7:8k |
| sns_ready | input | 1 | Sensor read-ready line |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle pulse when read-ready is seen |
| clk_handoff | output | 1 | Sensor clock released to the capture block |
| sns_clk | output | 1 | Sensor clock |
| sns_rst_n | output | 1 | Sensor reset, active low |
| sns_data | output | 1 | Serial configuration data |
| sns_load | output | 1 | Frame load strobe |
| sns_start | output | 1 | Start-of-exposure command |

## Verification
The bench first runs a session with the default register bytes and `sns_ready` raised after the first high phase. It then runs an alternating 0xAA/0x55 pattern, which catches bit-order and shift-length faults that a uniform value would hide. A session with `sns_ready` already high before the request shows that ready is sampled only after the start command. Sessions with random bytes and random ready delays check that frames, addresses and wait-phase edge counts follow the array and the delay. In some sessions the bench sends a second request while busy, and a restart would show up as an extra reset pulse or as frames out of order.

// File: rtl/img_seq_pkg.sv
`timescale 1ns/1ps
package img_seq_pkg;

   // One state per pin step; the step is taken on the next divider tick.
   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_RST_ASSERT,
      SQ_RST_CLKH,
      SQ_RST_RELEASE,
      SQ_RST_CLKL,
      SQ_BIT_SET,
      SQ_BIT_CLK,
      SQ_LD_RAISE,
      SQ_LD_CLKL,
      SQ_LD_DROP,
      SQ_GO_RAISE,
      SQ_GO_CLKH,
      SQ_GO_DROP,
      SQ_GO_CLKL,
      SQ_WT_CLKH,
      SQ_WT_SAMPLE
   } seq_state_e;

   typedef struct packed {
      logic clk;
      logic rst_n;
      logic data;
      logic load;
      logic start;
   } sns_pins_t;

   localparam sns_pins_t PINS_IDLE = '{clk: 1'b0, rst_n: 1'b1, data: 1'b0,
                                       load: 1'b0, start: 1'b0};

endpackage

// File: rtl/img_seq_tick.sv
`timescale 1ns/1ps
// Step pacing: one tick every HALF_CYC cycles while run is high.
module img_seq_tick #(
   parameter int HALF_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = $clog2(HALF_CYC + 1);
   localparam logic [CW-1:0] LIM = CW'(HALF_CYC - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt == LIM) cnt <= '0;
      else                 cnt <= cnt + CW'(1);
   end

   assign tick = run && (cnt == LIM);
endmodule

// File: rtl/img_seq_shift.sv
`timescale 1ns/1ps
// Frame shift register, MSB out first.
module img_seq_shift #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   output logic         msb
);
   logic [W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr <= '0;
      else if (load)  sr <= load_val;
      else if (shift) sr <= {sr[W-2:0], 1'b0};
   end

   assign msb = sr[W-1];
endmodule

// File: rtl/img_seq_src.sv
`timescale 1ns/1ps
// Register value source: parameter table or live input array.
module img_seq_src #(
   parameter int ADDR_W   = 3,
   parameter int DATA_W   = 8,
   parameter bit USE_PORT = 1'b0,
   parameter logic [(1<<ADDR_W)*DATA_W-1:0] INIT = '0
) (
   input  logic [(1<<ADDR_W)*DATA_W-1:0] cfg_in,
   input  logic [ADDR_W-1:0]             sel,
   output logic [DATA_W-1:0]             val
);
   localparam int NREG = 1 << ADDR_W;

   logic [DATA_W-1:0] tbl [NREG];

   if (USE_PORT) begin : g_port
      for (genvar i = 0; i < NREG; i++) begin : g_ent
         assign tbl[i] = cfg_in[i*DATA_W +: DATA_W];
      end
   end else begin : g_param
      logic cfg_unused;
      assign cfg_unused = ^cfg_in;
      for (genvar i = 0; i < NREG; i++) begin : g_ent
         assign tbl[i] = INIT[i*DATA_W +: DATA_W];
      end
   end

   assign val = tbl[sel];
endmodule

// File: rtl/img_seq_ctrl.sv
`timescale 1ns/1ps
module img_seq_ctrl
   import img_seq_pkg::*;
#(
   parameter int HALF_CYC = 4,
   parameter int ADDR_W   = 3,
   parameter int DATA_W   = 8,
   parameter bit USE_PORT = 1'b0,
   parameter logic [(1<<ADDR_W)*DATA_W-1:0] CFG_INIT = 64'h0301_0001_FF08_079F
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start_req,
   input  logic [(1<<ADDR_W)*DATA_W-1:0]  cfg_vals,
   input  logic                           sns_ready,
   output logic                           busy,
   output logic                           done,
   output logic                           clk_handoff,
   output logic                           sns_clk,
   output logic                           sns_rst_n,
   output logic                           sns_data,
   output logic                           sns_load,
   output logic                           sns_start
);
   localparam int FRAME_W = ADDR_W + DATA_W;
   localparam int BCW     = $clog2(FRAME_W);
   localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_W - 1);

   initial begin
      assert (HALF_CYC >= 1) else $error("HALF_CYC must be at least 1");
      assert (ADDR_W >= 1 && DATA_W >= 2) else $error("field widths too small");
   end

   seq_state_e        state;
   sns_pins_t         pins;
   logic [ADDR_W-1:0] reg_idx;
   logic [ADDR_W-1:0] sel_idx;
   logic [BCW-1:0]    bit_cnt;
   logic [DATA_W-1:0] src_val;
   logic              tick;
   logic              frm_load;
   logic              frm_shift;
   logic              frm_msb;
   logic              last_reg;

   assign busy     = (state != SQ_IDLE);
   assign last_reg = &reg_idx;
   assign sel_idx  = (state == SQ_LD_DROP) ? reg_idx + ADDR_W'(1) : reg_idx;

   assign frm_load  = tick && ((state == SQ_RST_CLKL) ||
                               (state == SQ_LD_DROP && !last_reg));
   assign frm_shift = tick && (state == SQ_BIT_CLK);

   img_seq_tick #(.HALF_CYC(HALF_CYC)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .tick  (tick)
   );

   img_seq_src #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .USE_PORT (USE_PORT),
      .INIT     (CFG_INIT)
   ) u_src (
      .cfg_in (cfg_vals),
      .sel    (sel_idx),
      .val    (src_val)
   );

   img_seq_shift #(.W(FRAME_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (frm_load),
      .load_val ({sel_idx, src_val}),
      .shift    (frm_shift),
      .msb      (frm_msb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= SQ_IDLE;
         pins        <= PINS_IDLE;
         reg_idx     <= '0;
         bit_cnt     <= '0;
         done        <= 1'b0;
         clk_handoff <= 1'b0;
      end else begin
         done <= 1'b0;
         if (state == SQ_IDLE) begin
            if (start_req) begin
               state       <= SQ_RST_ASSERT;
               clk_handoff <= 1'b0;
               reg_idx     <= '0;
            end
         end else if (tick) begin
            case (state)
               SQ_RST_ASSERT: begin pins.rst_n <= 1'b0; state <= SQ_RST_CLKH;    end
               SQ_RST_CLKH:   begin pins.clk   <= 1'b1; state <= SQ_RST_RELEASE; end
               SQ_RST_RELEASE:begin pins.rst_n <= 1'b1; state <= SQ_RST_CLKL;    end
               SQ_RST_CLKL: begin
                  pins.clk <= 1'b0;
                  bit_cnt  <= '0;
                  state    <= SQ_BIT_SET;
               end
               SQ_BIT_SET: begin
                  pins.clk  <= 1'b0;
                  pins.data <= frm_msb;
                  state     <= SQ_BIT_CLK;
               end
               SQ_BIT_CLK: begin
                  pins.clk <= 1'b1;
                  if (bit_cnt == LAST_BIT) begin
                     state <= SQ_LD_RAISE;
                  end else begin
                     bit_cnt <= bit_cnt + BCW'(1);
                     state   <= SQ_BIT_SET;
                  end
               end
               SQ_LD_RAISE: begin pins.load <= 1'b1; state <= SQ_LD_CLKL; end
               SQ_LD_CLKL: begin
                  pins.clk  <= 1'b0;
                  pins.data <= 1'b0;
                  state     <= SQ_LD_DROP;
               end
               SQ_LD_DROP: begin
                  pins.load <= 1'b0;
                  bit_cnt   <= '0;
                  if (last_reg) begin
                     state <= SQ_GO_RAISE;
                  end else begin
                     reg_idx <= reg_idx + ADDR_W'(1);
                     state   <= SQ_BIT_SET;
                  end
               end
               SQ_GO_RAISE: begin pins.start <= 1'b1; state <= SQ_GO_CLKH; end
               SQ_GO_CLKH:  begin pins.clk   <= 1'b1; state <= SQ_GO_DROP; end
               SQ_GO_DROP:  begin pins.start <= 1'b0; state <= SQ_GO_CLKL; end
               SQ_GO_CLKL:  begin pins.clk   <= 1'b0; state <= SQ_WT_CLKH; end
               SQ_WT_CLKH:  begin pins.clk   <= 1'b1; state <= SQ_WT_SAMPLE; end
               SQ_WT_SAMPLE: begin
                  pins.clk <= 1'b0;
                  if (sns_ready) begin
                     done        <= 1'b1;
                     clk_handoff <= 1'b1;
                     state       <= SQ_IDLE;
                  end else begin
                     state <= SQ_WT_CLKH;
                  end
               end
               default: state <= SQ_IDLE;
            endcase
         end
      end
   end

   assign sns_clk   = pins.clk;
   assign sns_rst_n = pins.rst_n;
   assign sns_data  = pins.data;
   assign sns_load  = pins.load;
   assign sns_start = pins.start;
endmodule

// File: rtl/img_seq_ctrl_chk.sv
`timescale 1ns/1ps
module img_seq_ctrl_chk #(
   parameter int HALF_CYC = 4
) (
   input logic clk,
   input logic rst_n,
   input logic start_req,
   input logic sns_ready,
   input logic busy,
   input logic done,
   input logic clk_handoff,
   input logic sns_clk,
   input logic sns_rst_n,
   input logic sns_data,
   input logic sns_load,
   input logic sns_start
);
   localparam int CNT_W = 16;

   logic [CNT_W-1:0] ph_cnt;
   logic             clk_q;

   // Cycles since the sensor clock last changed level.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_cnt <= '1;
         clk_q  <= 1'b0;
      end else begin
         clk_q <= sns_clk;
         if (sns_clk != clk_q)  ph_cnt <= CNT_W'(1);
         else if (ph_cnt != '1) ph_cnt <= ph_cnt + CNT_W'(1);
      end
   end

   p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!sns_clk && sns_rst_n && !sns_load && !sns_start));

   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start_req) |=> busy);

   p_busy_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done));

   p_rst_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sns_rst_n) |-> !sns_clk);

   p_rst_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sns_rst_n) |-> sns_clk);

   p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sns_clk && $past(sns_clk)) |-> $stable(sns_data));

   p_load_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sns_load) |-> sns_clk);

   p_load_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sns_load) |-> !sns_clk);

   p_start_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sns_start) |-> !sns_clk);

   p_start_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sns_start) |-> sns_clk);

   p_ready_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(sns_ready) && $past(sns_clk)));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy) && !sns_clk && clk_handoff));

   p_phase_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sns_clk != clk_q) |-> (ph_cnt >= CNT_W'(HALF_CYC)));

   p_one_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({sns_clk, sns_rst_n, sns_load, sns_start} ^
                 $past({sns_clk, sns_rst_n, sns_load, sns_start})) <= 1);
endmodule

bind img_seq_ctrl img_seq_ctrl_chk #(.HALF_CYC(HALF_CYC)) u_chk (.*);

// File: tb/sim_img_seq_ctrl.sv
`timescale 1ns/1ps
module sim_img_seq_ctrl;
   localparam int HALF = 3;
   localparam int NREG = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_req = 1'b0;
   logic        sns_ready = 1'b0;
   logic [63:0] cfg_vals = '0;
   logic busy, done, clk_handoff, sns_clk, sns_rst_n, sns_data, sns_load, sns_start;

   img_seq_ctrl #(.HALF_CYC(HALF), .USE_PORT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .cfg_vals(cfg_vals),
      .sns_ready(sns_ready), .busy(busy), .done(done), .clk_handoff(clk_handoff),
      .sns_clk(sns_clk), .sns_rst_n(sns_rst_n), .sns_data(sns_data),
      .sns_load(sns_load), .sns_start(sns_start)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: act=%0h exp=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] dflt_byte(input int i);
      logic [63:0] t;
      t = 64'h0301_0001_FF08_079F;
      return t[i*8 +: 8];
   endfunction

   function automatic logic [10:0] exp_frame(input int idx, input logic [63:0] vals);
      return {idx[2:0], vals[idx*8 +: 8]};
   endfunction

   // Port monitor, sampled on falling system clock edges.
   logic        mon_clear = 1'b0;
   logic        p_clk = 1'b0, p_rst = 1'b1, p_load = 1'b0, p_start = 1'b0, p_data = 1'b0;
   int          rst_rises = 0, start_rises = 0, wait_rises = 0;
   int          nframes = 0, nbits = 0, data_viol = 0, ph_viol = 0, ph_cnt = 1000;
   bit          started = 1'b0;
   logic [10:0] sh = '0;

   always @(negedge clk) begin
      if (mon_clear) begin
         rst_rises = 0; start_rises = 0; wait_rises = 0;
         nframes = 0; nbits = 0; data_viol = 0; started = 1'b0; sh = '0;
      end else if (rst_n) begin
         if (sns_clk && !p_clk) begin
            if (!sns_rst_n)      rst_rises++;
            else if (sns_start)  start_rises++;
            else if (started)    wait_rises++;
            else if (!sns_load) begin
               sh = {sh[9:0], sns_data};
               nbits++;
            end
         end
         if (!sns_rst_n && p_rst)  chk(!sns_clk, "R3 reset falls with clock low", sns_clk, 0);
         if (sns_rst_n && !p_rst)  chk(sns_clk,  "R3 reset rises with clock high", sns_clk, 1);
         if (sns_start && !p_start) begin
            chk(!sns_clk, "R7 start rises with clock low", sns_clk, 0);
            started = 1'b1;
         end
         if (!sns_start && p_start) chk(sns_clk, "R7 start falls with clock high", sns_clk, 1);
         if (sns_load && !p_load) begin
            chk(sns_clk, "R6 load rises with clock high", sns_clk, 1);
            chk(nbits == 11, "R4 bits per frame", nbits, 11);
            if (nframes < NREG)
               chk(sh == exp_frame(nframes, cfg_vals), "R4 frame content", sh,
                   exp_frame(nframes, cfg_vals));
            nframes++;
            nbits = 0;
         end
         if (!sns_load && p_load) chk(!sns_clk, "R6 load falls with clock low", sns_clk, 0);
         if (sns_clk && p_clk && (sns_data != p_data)) data_viol++;
         if (sns_clk != p_clk) begin
            if (ph_cnt < HALF) ph_viol++;
            ph_cnt = 1;
         end else if (ph_cnt < 1000) begin
            ph_cnt++;
         end
      end
      p_clk = sns_clk; p_rst = sns_rst_n; p_load = sns_load;
      p_start = sns_start; p_data = sns_data;
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   task automatic run_session(input logic [63:0] vals, input int k, input bit inject,
                              input bit pre_ready);
      @(negedge clk);
      cfg_vals  = vals;
      sns_ready = pre_ready;
      mon_clear = 1'b1;
      @(negedge clk);
      mon_clear = 1'b0;
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      chk(busy == 1'b1, "R2 busy after accepted start", busy, 1);
      chk(clk_handoff == 1'b0, "R2 handoff cleared on start", clk_handoff, 0);
      if (inject) begin
         wait (nframes == 3);
         start_req = 1'b1;
         @(negedge clk);
         start_req = 1'b0;
      end
      if (!pre_ready) begin
         wait (wait_rises == k);
         sns_ready = 1'b1;
      end
      while (!done) @(negedge clk);
      chk(busy == 1'b0, "R9 busy drops with done", busy, 0);
      chk(sns_clk == 1'b0, "R9 clock left low", sns_clk, 0);
      chk(wait_rises == (pre_ready ? 1 : k), "R8 wait-phase rising edges", wait_rises,
          pre_ready ? 1 : k);
      @(negedge clk);
      chk(done == 1'b0, "R9 done lasts one cycle", done, 0);
      chk(clk_handoff == 1'b1, "R9 handoff after done", clk_handoff, 1);
      chk(sns_rst_n && !sns_load && !sns_start && !busy, "R1 idle pins after session",
          {sns_rst_n, sns_load, sns_start, busy}, 4'b1000);
      chk(nframes == NREG, "R4 frame count (R2 no restart)", nframes, NREG);
      chk(rst_rises == 1, "R3 one clock edge in reset (R2 no restart)", rst_rises, 1);
      chk(start_rises == 1, "R7 one clock edge with start high", start_rises, 1);
      chk(data_viol == 0, "R5 data changes while clock high", data_viol, 0);
      chk(ph_viol == 0, "R10 short clock phase", ph_viol, 0);
      sns_ready = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL R8 watchdog: act=timeout exp=done");
      summary();
      $finish;
   end

   initial begin
      logic [63:0] dvals;
      logic [63:0] rvals;
      int          seed_disc;
      seed_disc = $urandom(32'd20240611);
      dvals = '0;
      for (int i = 0; i < NREG; i++) dvals[i*8 +: 8] = dflt_byte(i);

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !clk_handoff, "R1 status after reset",
          {busy, done, clk_handoff}, 0);
      chk(!sns_clk && sns_rst_n && !sns_load && !sns_start && !sns_data,
          "R1 pins after reset", {sns_clk, sns_rst_n, sns_load, sns_start, sns_data},
          5'b01000);

      run_session(dvals, 1, 1'b0, 1'b0);
      run_session(64'h55AA_55AA_55AA_55AA, 3, 1'b1, 1'b0);
      run_session(64'h8001_7FFE_0000_FFFF, 1, 1'b0, 1'b1);
      for (int s = 0; s < 5; s++) begin
         rvals = {$urandom, $urandom};
         run_session(rvals, int'($urandom_range(1, 6)), bit'($urandom_range(0, 1)), 1'b0);
      end

      summary();
      $finish;
   end
endmodule